// File: doc/BRIEF.md
# Generator-Store Block Forwarding Buffer

This block sits next to a core's private second-level cache. It watches the store-commit stream. When a committed store carries the generator tag, the block keeps that store's cache-block address, with the 6 offset bits dropped for 64-byte blocks. It keeps no data. The addresses may come in any order; the block looks for no stride and no pattern. A block address that is already held is not stored twice. The table holds 16 entries of 48 bits each.

A forward command names the core that will run the next program segment. On that command the block empties its table. It sends each held address once, in the order it was recorded, as a push request to that core. The cache then copies the block into the remote core's cache before the next segment starts, so that segment's reads hit.

While the table is being emptied, the store-commit side is held off with a stall signal. The push port is valid/ready. A request that is offered stays unchanged until it is accepted, and at most one request is accepted per clock.

Top module: `xfer_block_buf`

## Requirements
- R1: A store recorded while idle adds the block address `st_addr[53:6]` only when `st_valid` and `st_gen` are both high; a store with `st_gen` low leaves the table unchanged.
- R2: A generator store whose block address equals a held entry adds no entry, so two stores that differ only in bits [5:0] cause one push.
- R3: The table holds 16 entries. A generator store with a new block address that arrives when all 16 are full is dropped and sets `overflow`. `overflow` then stays high until reset, including through drains.
- R4: `cmd_valid` while idle starts a drain. Every held address is offered exactly once on `push_blk`, oldest first, with `push_dest` equal to the `cmd_dest` sampled with the command.
- R5: While `push_valid` is high and `push_ready` is low, the next cycle still has `push_valid` high with `push_blk` and `push_dest` unchanged. A request is consumed only on a cycle where both are high.
- R6: `st_stall` is high from the cycle after the command until the drain ends. Stores presented while `st_stall` is high are not recorded.
- R7: `drain_done` is high for exactly one cycle after the last push is accepted, or after the command if the table was empty. After it, the table is empty.
- R8: A synchronous reset (`rst` high at a clock edge) empties the table, clears `overflow`, and returns the block to idle with no request offered.
- R9: A generator store presented in the same cycle as the command is recorded and is included in that drain. Commands presented during a drain are ignored and do not change `push_dest`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | A store commits this cycle |
| st_addr | input | 54 | Physical byte address of the store |
| st_gen | input | 1 | Store carries the generator tag |
| st_stall | output | 1 | Store side must hold off (drain in progress) |
| cmd_valid | input | 1 | Forward command |
| cmd_dest | input | 5 | Destination core of the command |
| push_valid | output | 1 | Push request offered |
| push_ready | input | 1 | Cache accepts the push request |
| push_blk | output | 48 | Block address to forward |
| push_dest | output | 5 | Core that receives the block |
| drain_done | output | 1 | One-cycle pulse when a drain has finished |
| overflow | output | 1 | Sticky flag: a generator store was dropped because the table was full |

## Verification
Random rounds mix untagged stores, fresh tagged addresses, and tagged stores that reuse a recent block with another offset. This separates filtering by the tag from merging of duplicates. Each round is drained with a random chance of `push_ready`, which shows whether order and hold-under-back-pressure survive stalls. Directed cases cover the following:
- a store arriving in the same cycle as the command;
- a command on an empty table;
- stores and commands injected mid-drain;
- a full table overflowing;
- a reset while entries are held.

Each of these has a visible signature in the push sequence or the flag.

// File: rtl/xfb_pkg.sv
`timescale 1ns/1ps
package xfb_pkg;
  typedef enum logic {
    XS_IDLE  = 1'b0,
    XS_DRAIN = 1'b1
  } xfb_state_e;
endpackage

// File: rtl/xfb_match.sv
`timescale 1ns/1ps
// Parallel compare of a probe block address against all live entries.
module xfb_match #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 48
) (
  input  logic [DEPTH-1:0][BLK_W-1:0] tags,
  input  logic [DEPTH-1:0]            live,
  input  logic [BLK_W-1:0]            probe,
  output logic                        hit
);
  logic [DEPTH-1:0] hv;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hv[i] = live[i] && (tags[i] == probe);
  end

  assign hit = |hv;
endmodule

// File: rtl/xfb_store.sv
`timescale 1ns/1ps
// Entry array: one tag register and one live bit per slot.
module xfb_store #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [BLK_W-1:0]            wr_blk,
  input  logic                        clr_en,
  input  logic [IDX_W-1:0]            clr_idx,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [BLK_W-1:0]            rd_blk,
  output logic [DEPTH-1:0][BLK_W-1:0] tags,
  output logic [DEPTH-1:0]            live
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        live[i] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        live[i] <= 1'b1;
      end else if (clr_en && (clr_idx == IDX_W'(i))) begin
        live[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) tags[i] <= wr_blk;
    end
  end

  assign rd_blk = tags[rd_idx];
endmodule

// File: rtl/xfer_block_buf.sv
`timescale 1ns/1ps
// Records generator-tagged store block addresses and forwards them to a
// named core on command.
module xfer_block_buf #(
  parameter int PA_W   = 54,
  parameter int OFF_W  = 6,
  parameter int DEPTH  = 16,
  parameter int CORE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  input  logic [PA_W-1:0]         st_addr,
  input  logic                    st_gen,
  output logic                    st_stall,
  input  logic                    cmd_valid,
  input  logic [CORE_W-1:0]       cmd_dest,
  output logic                    push_valid,
  input  logic                    push_ready,
  output logic [PA_W-OFF_W-1:0]   push_blk,
  output logic [CORE_W-1:0]       push_dest,
  output logic                    drain_done,
  output logic                    overflow
);
  import xfb_pkg::*;

  localparam int BLK_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  xfb_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    rd_q;
  logic [CORE_W-1:0]   dest_q;
  logic                ovf_q;
  logic                done_q;

  logic [BLK_W-1:0]             st_blk;
  logic [DEPTH-1:0][BLK_W-1:0]  tags;
  logic [DEPTH-1:0]             live;
  logic                         hit;
  logic                         idle;
  logic                         full;
  logic                         take;
  logic                         alloc;
  logic                         drop;
  logic                         fire;

  assign idle   = (state_q == XS_IDLE);
  assign st_blk = st_addr[PA_W-1:OFF_W];
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign take   = st_valid && st_gen && idle;
  assign alloc  = take && !hit && !full;
  assign drop   = take && !hit && full;

  assign push_valid = !idle && (rd_q < cnt_q);
  assign fire       = push_valid && push_ready;

  xfb_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
    .tags  (tags),
    .live  (live),
    .probe (st_blk),
    .hit   (hit)
  );

  xfb_store #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (alloc),
    .wr_idx  (cnt_q[IDX_W-1:0]),
    .wr_blk  (st_blk),
    .clr_en  (fire),
    .clr_idx (rd_q[IDX_W-1:0]),
    .rd_idx  (rd_q[IDX_W-1:0]),
    .rd_blk  (push_blk),
    .tags    (tags),
    .live    (live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
      rd_q    <= '0;
      dest_q  <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (alloc) cnt_q <= cnt_q + 1'b1;
      if (drop)  ovf_q <= 1'b1;
      unique case (state_q)
        XS_IDLE: begin
          if (cmd_valid) begin
            state_q <= XS_DRAIN;
            dest_q  <= cmd_dest;
            rd_q    <= '0;
          end
        end
        XS_DRAIN: begin
          if (fire) begin
            rd_q <= rd_q + 1'b1;
          end else if (rd_q == cnt_q) begin
            state_q <= XS_IDLE;
            cnt_q   <= '0;
            rd_q    <= '0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign st_stall   = !idle;
  assign push_dest  = dest_q;
  assign drain_done = done_q;
  assign overflow   = ovf_q;
endmodule

// File: rtl/xfb_chk.sv
`timescale 1ns/1ps
module xfb_chk #(
  parameter int BLK_W  = 48,
  parameter int CORE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              st_stall,
  input logic              push_valid,
  input logic              push_ready,
  input logic [BLK_W-1:0]  push_blk,
  input logic [CORE_W-1:0] push_dest,
  input logic              drain_done,
  input logic              overflow
);
  // R5: an offered request is held unchanged until accepted
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    push_valid && !push_ready |=> push_valid && $stable(push_blk) && $stable(push_dest));

  // R6: requests only appear while the store side is stalled
  a_r6_push_in_drain: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> st_stall);

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    drain_done |=> !drain_done);

  // R7: on completion nothing is offered and stores are released
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> !push_valid && !st_stall);

  // R3: the overflow flag is sticky
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R4: destination stays fixed across back-to-back requests of one drain
  a_r4_dest_steady: assert property (@(posedge clk) disable iff (rst)
    push_valid && $past(push_valid) |-> $stable(push_dest));
endmodule

bind xfer_block_buf xfb_chk #(.BLK_W(PA_W - OFF_W), .CORE_W(CORE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st_stall   (st_stall),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .push_blk   (push_blk),
  .push_dest  (push_dest),
  .drain_done (drain_done),
  .overflow   (overflow)
);

// File: tb/xfer_block_buf_bench.sv
`timescale 1ns/1ps
module xfer_block_buf_bench;
  localparam int PA_W = 54;
  localparam int BW   = 48;
  localparam int CW   = 5;
  localparam int CAP  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          st_valid = 1'b0;
  logic [PA_W-1:0] st_addr = '0;
  logic          st_gen = 1'b0;
  logic          st_stall;
  logic          cmd_valid = 1'b0;
  logic [CW-1:0] cmd_dest = '0;
  logic          push_valid;
  logic          push_ready = 1'b0;
  logic [BW-1:0] push_blk;
  logic [CW-1:0] push_dest;
  logic          drain_done;
  logic          overflow;

  int n_chk = 0;
  int n_bad = 0;
  logic [BW-1:0] mq [CAP];
  int  mcnt = 0;
  bit  movf = 1'b0;
  logic [PA_W-1:0] last_addr = '0;
  int unsigned seed_val;

  always #2 clk = ~clk;

  xfer_block_buf u_xfer_block_buf (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_gen(st_gen),
    .st_stall(st_stall), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
    .push_valid(push_valid), .push_ready(push_ready), .push_blk(push_blk),
    .push_dest(push_dest), .drain_done(drain_done), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_model(input logic [BW-1:0] b);
    for (int i = 0; i < mcnt; i++) if (mq[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void model_store(input logic [PA_W-1:0] a, input bit g);
    logic [BW-1:0] b;
    b = a[PA_W-1:6];
    if (!g) return;
    if (in_model(b)) return;
    if (mcnt < CAP) begin mq[mcnt] = b; mcnt++; end
    else movf = 1'b1;
  endfunction

  function automatic logic [PA_W-1:0] rnd_addr();
    return {$urandom, $urandom};
  endfunction

  task automatic store(input logic [PA_W-1:0] a, input bit g);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_gen = g;
    #1 chk(st_stall == 1'b0, "R6 stall low while idle", 64'(st_stall), 64'd0);
    model_store(a, g);
    last_addr = a;
    @(negedge clk);
    st_valid = 1'b0; st_gen = 1'b0;
  endtask

  // Drain with optional same-cycle store (R9) and mid-drain injection (R6/R9).
  task automatic drain(input logic [CW-1:0] dest, input int rdy_pct,
                       input bit with_store, input logic [PA_W-1:0] sa, input bit inject);
    int idx = 0;
    int guard = 0;
    bit have_prev = 1'b0;
    logic [BW-1:0] prev = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dest = dest;
    if (with_store) begin
      st_valid = 1'b1; st_gen = 1'b1; st_addr = sa;
      model_store(sa, 1'b1);
    end
    @(negedge clk);
    cmd_valid = 1'b0; st_valid = 1'b0; st_gen = 1'b0;
    while (guard < 2000) begin
      push_ready = (($urandom % 100) < rdy_pct);
      if (inject && guard == 0) begin
        st_valid = 1'b1; st_gen = 1'b1; st_addr = rnd_addr();
        cmd_valid = 1'b1; cmd_dest = ~dest;
      end else begin
        st_valid = 1'b0; st_gen = 1'b0; cmd_valid = 1'b0;
      end
      #1;
      if (drain_done) break;
      chk(st_stall == 1'b1, "R6 stall high during drain", 64'(st_stall), 64'd1);
      if (have_prev)
        chk(push_valid && push_blk == prev, "R5 request held under back-pressure",
            64'(push_blk), 64'(prev));
      if (push_valid) begin
        chk(push_dest == dest, "R4/R9 push destination", 64'(push_dest), 64'(dest));
        if (push_ready) begin
          chk(idx < mcnt && push_blk == mq[idx], "R4 push order and address",
              64'(push_blk), (idx < mcnt) ? 64'(mq[idx]) : 64'hDEAD);
          idx++;
          have_prev = 1'b0;
        end else begin
          have_prev = 1'b1; prev = push_blk;
        end
      end
      @(negedge clk);
      guard++;
    end
    st_valid = 1'b0; st_gen = 1'b0; cmd_valid = 1'b0; push_ready = 1'b0;
    chk(drain_done == 1'b1, "R7 drain finished", 64'(drain_done), 64'd1);
    chk(idx == mcnt, "R4 number of pushes", 64'(idx), 64'(mcnt));
    chk(!push_valid && !st_stall, "R7 idle after done", 64'({push_valid, st_stall}), 64'd0);
    @(negedge clk); #1;
    chk(drain_done == 1'b0, "R7 done is one cycle", 64'(drain_done), 64'd0);
    mcnt = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    seed_val = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!push_valid && !st_stall && !overflow && !drain_done, "R8 reset state",
        64'({push_valid, st_stall, overflow, drain_done}), 64'd0);

    // R1: untagged stores ignored, tagged recorded
    store(54'h0000_1234_5640, 1'b0);
    store(54'h0000_AAAA_0000, 1'b1);
    store(54'h0000_BBBB_00C0, 1'b0);
    store(54'h0001_0000_0040, 1'b1);
    drain(5'd3, 100, 1'b0, '0, 1'b0);

    // R2: same block different offsets merge
    store(54'h0000_7777_0000, 1'b1);
    store(54'h0000_7777_003F, 1'b1);
    store(54'h0000_7777_0015, 1'b1);
    store(54'h0000_7777_0040, 1'b1);
    drain(5'd9, 60, 1'b0, '0, 1'b0);

    // R9: store in the command cycle is included
    store(54'h0000_0101_0000, 1'b1);
    drain(5'd17, 100, 1'b1, 54'h0000_0202_0080, 1'b0);

    // R7: empty drain
    drain(5'd1, 100, 1'b0, '0, 1'b0);

    // R6/R9: injected store and command during drain are ignored
    store(54'h0000_3030_0000, 1'b1);
    store(54'h0000_4040_0000, 1'b1);
    drain(5'd22, 40, 1'b0, '0, 1'b1);
    drain(5'd2, 100, 1'b0, '0, 1'b0);

    // R3: overflow
    for (int i = 0; i < CAP + 3; i++) store(54'(64'h1000 + 64'(i) * 64'h40), 1'b1);
    store(54'h1000, 1'b1);  // duplicate of a held entry while full: not a drop
    #1 chk(overflow == 1'b1, "R3 overflow set when full", 64'(overflow), 64'd1);
    drain(5'd30, 70, 1'b0, '0, 1'b0);
    #1 chk(overflow == 1'b1, "R3 overflow sticky through drain", 64'(overflow), 64'd1);

    // R8: reset clears table and flag
    store(54'h0000_9999_0000, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mcnt = 0; movf = 1'b0;
    #1 chk(overflow == 1'b0, "R8 overflow cleared", 64'(overflow), 64'd0);
    drain(5'd4, 100, 1'b0, '0, 1'b0);

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      int n;
      n = $urandom % 24;
      for (int k = 0; k < n; k++) begin
        int pick;
        logic [PA_W-1:0] a;
        pick = $urandom % 10;
        if (pick < 3 && k > 0) a = {last_addr[PA_W-1:6], 6'($urandom)};
        else a = rnd_addr();
        store(a, ($urandom % 4) != 0);
      end
      #1 chk(overflow == movf, "R3 overflow matches model", 64'(overflow), 64'(movf));
      drain(5'($urandom), 30 + ($urandom % 71), ($urandom % 5) == 0, rnd_addr(),
            ($urandom % 4) == 0);
    end

    finish_run();
  end
endmodule